// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block collects 32 level-sensitive interrupt lines and raises one request to the processor. Software gives each line its own 32-bit handler address and a 4-bit priority level. Before arbitration, each line is gated by its enable bit and by a mask that software sets per priority level. Among the surviving lines, the arbiter picks the one at the most urgent level. The request pin goes high only when that winner is more urgent than the interrupt the processor is already servicing.

Software reads the active-vector word to get the handler address of the winner. That read is also the acknowledge: the winner's level is pushed onto a hardware priority stack, and its address is latched. At the end of the handler, software writes any value to the same word. The write pops the stack, and the previous service level is restored.

The register port is plain control: select, write strobe, word address and data. Every access completes in the cycle it is presented. There is no back-pressure, and read data is valid combinationally in that cycle.

Word map:

| Words | Content |
|---|---|
| 0x00+n | Handler address of source n |
| 0x20+n | Priority of source n |
| 0x40 | Enable register |
| 0x41 | Level mask register |
| 0x42 | Active-vector word |

Top module: `vec_irq_ctrl`

## Requirements
- R1: After reset, `cpu_irq` is low. Every handler address, every priority field and the enable word (0x40) read zero. The level mask (0x41) reads 0x0000FFFF, and the active-vector word (0x42) reads 0.
- R2: Word 0x00+n is a 32-bit read/write handler address for source n. Word 0x20+n holds a 4-bit priority in bits [3:0], and its upper bits read zero. Words above 0x42 read zero, and writes to them are ignored.
- R3: Source n takes part in arbitration only when all of the following hold: its line is high, enable bit n of word 0x40 is 1, and bit p of word 0x41 is 1, where p is its priority. A mask bit of 0 masks that level.
- R4: Priority value 0 is the most urgent and 15 the least. Among sources at the same level, the lowest source number wins.
- R5: `cpu_irq` is registered. It goes high on the first clock edge after a qualifying request appears, not in the same cycle.
- R6: A read of word 0x42 while a request qualifies returns the winner's handler address, latches that address, and pushes the winner's level onto the service stack.
- R7: While level L is being serviced, only a source at a level numerically below L can raise `cpu_irq`. A source at level L itself, or at a less urgent level, keeps it low.
- R8: A write of any data to word 0x42 pops one level and restores the previous service level. A write while nothing is being serviced has no effect.
- R9: A read of word 0x42 when no request qualifies returns the last latched address and leaves the service stack unchanged.
- R10: Service can nest through all 16 levels. Each acknowledge returns the correct handler, and the stack never exceeds 16 entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_lines | input | 32 | Level-sensitive interrupt requests, one per source |
| bus_sel | input | 1 | Register access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the access cycle |
| cpu_irq | output | 1 | Registered interrupt request to the processor |

## Verification
The hardest state to reach from the ports is a fully stacked service chain. In that state all sixteen levels are acknowledged in turn, a second source ties with the most urgent serviced level, and a retire has to re-expose a pending source rather than clear the request. The stimulus reaches it by raising source lines one at a time in order of rising urgency and acknowledging each before the next appears. It then adds a tying line and retires. A second sequence shows that an idle acknowledge left the stack untouched: after an idle read, a single retire must be enough to let a less urgent source through.

// File: rtl/vec_irq_pkg.sv
package vec_irq_pkg;

  typedef enum logic [2:0] {
    RG_VEC,
    RG_PRIO,
    RG_EN,
    RG_MASK,
    RG_ACT,
    RG_NONE
  } reg_region_e;

  // Word map: n handler words, n priority words, then enable, mask, active.
  function automatic reg_region_e region_of(input int unsigned a, input int unsigned n);
    if (a < n)               return RG_VEC;
    else if (a < 2 * n)      return RG_PRIO;
    else if (a == 2 * n)     return RG_EN;
    else if (a == 2 * n + 1) return RG_MASK;
    else if (a == 2 * n + 2) return RG_ACT;
    else                     return RG_NONE;
  endfunction

endpackage

// File: rtl/vec_irq_regs.sv
module vec_irq_regs
  import vec_irq_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int DATA_W  = 32,
  parameter int PRIO_W  = 4,
  parameter int ADDR_W  = 8
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             wr_en,
  input  logic [ADDR_W-1:0]                addr,
  input  logic [DATA_W-1:0]                wdata,
  output logic [DATA_W-1:0]                rdata,
  output logic [NUM_SRC-1:0][DATA_W-1:0]   vec_tbl,
  output logic [NUM_SRC-1:0][PRIO_W-1:0]   prio_tbl,
  output logic [NUM_SRC-1:0]               src_en,
  output logic [(1<<PRIO_W)-1:0]           lvl_mask
);

  localparam int NUM_LVL = 1 << PRIO_W;
  localparam int IDX_W   = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

  logic [NUM_SRC-1:0][DATA_W-1:0] vec_q;
  logic [NUM_SRC-1:0][PRIO_W-1:0] prio_q;
  logic [NUM_SRC-1:0]             en_q;
  logic [NUM_LVL-1:0]             mask_q;

  reg_region_e       rgn;
  logic [ADDR_W-1:0] rel;
  logic [IDX_W-1:0]  sel_idx;

  assign rgn     = region_of(32'(addr), NUM_SRC);
  assign rel     = (rgn == RG_PRIO) ? addr - ADDR_W'(NUM_SRC) : addr;
  assign sel_idx = rel[IDX_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vec_q  <= '0;
      prio_q <= '0;
      en_q   <= '0;
      mask_q <= '1;
    end else if (wr_en) begin
      case (rgn)
        RG_VEC:  vec_q[sel_idx]  <= wdata;
        RG_PRIO: prio_q[sel_idx] <= wdata[PRIO_W-1:0];
        RG_EN:   en_q            <= wdata[NUM_SRC-1:0];
        RG_MASK: mask_q          <= wdata[NUM_LVL-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    case (rgn)
      RG_VEC:  rdata = vec_q[sel_idx];
      RG_PRIO: rdata = DATA_W'(prio_q[sel_idx]);
      RG_EN:   rdata = DATA_W'(en_q);
      RG_MASK: rdata = DATA_W'(mask_q);
      default: rdata = '0;
    endcase
  end

  assign vec_tbl  = vec_q;
  assign prio_tbl = prio_q;
  assign src_en   = en_q;
  assign lvl_mask = mask_q;

endmodule

// File: rtl/vec_irq_arb.sv
module vec_irq_arb #(
  parameter int NUM_SRC = 32,
  parameter int PRIO_W  = 4
) (
  input  logic [NUM_SRC-1:0]             irq_lines,
  input  logic [NUM_SRC-1:0]             src_en,
  input  logic [(1<<PRIO_W)-1:0]         lvl_mask,
  input  logic [NUM_SRC-1:0][PRIO_W-1:0] prio_tbl,
  output logic                           win_valid,
  output logic [((NUM_SRC>1)?$clog2(NUM_SRC):1)-1:0] win_idx,
  output logic [PRIO_W-1:0]              win_prio
);

  localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;
  localparam int LV    = IDX_W;
  localparam int N2    = 1 << LV;

  logic [NUM_SRC-1:0] pend;

  // Per-source gating: line, enable, and the mask bit of its own level.
  for (genvar s = 0; s < NUM_SRC; s++) begin : g_gate
    assign pend[s] = irq_lines[s] & src_en[s] & lvl_mask[prio_tbl[s]];
  end

  logic              nv [2*N2];
  logic [PRIO_W-1:0] np [2*N2];
  logic [IDX_W-1:0]  ni [2*N2];

  // Tournament tree, heap ordered; the left child holds lower indices and wins ties.
  always_comb begin
    for (int k = 0; k < 2 * N2; k++) begin
      nv[k] = 1'b0;
      np[k] = '0;
      ni[k] = '0;
    end
    for (int s = 0; s < N2; s++) begin
      if (s < NUM_SRC) begin
        nv[N2+s] = pend[s];
        np[N2+s] = prio_tbl[s];
      end
      ni[N2+s] = IDX_W'(s);
    end
    for (int k = N2 - 1; k >= 1; k--) begin
      if (nv[2*k] && (!nv[2*k+1] || np[2*k] <= np[2*k+1])) begin
        nv[k] = 1'b1;
        np[k] = np[2*k];
        ni[k] = ni[2*k];
      end else begin
        nv[k] = nv[2*k+1];
        np[k] = np[2*k+1];
        ni[k] = ni[2*k+1];
      end
    end
  end

  assign win_valid = nv[1];
  assign win_prio  = np[1];
  assign win_idx   = ni[1];

endmodule

// File: rtl/vec_irq_stack.sv
module vec_irq_stack #(
  parameter int PRIO_W = 4
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             push,
  input  logic [PRIO_W-1:0]                push_lvl,
  input  logic                             pop,
  output logic                             empty,
  output logic [PRIO_W-1:0]                top_lvl,
  output logic [$clog2((1<<PRIO_W)+1)-1:0] depth
);

  localparam int DEPTH = 1 << PRIO_W;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [PRIO_W-1:0] mem [DEPTH];
  logic [CNT_W-1:0]  cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (push && cnt_q < CNT_W'(DEPTH)) begin
      cnt_q <= cnt_q + 1'b1;
    end else if (pop && cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (push && cnt_q < CNT_W'(DEPTH)) mem[PRIO_W'(cnt_q)] <= push_lvl;
  end

  assign empty   = (cnt_q == '0);
  assign top_lvl = empty ? '0 : mem[PRIO_W'(cnt_q - 1'b1)];
  assign depth   = cnt_q;

endmodule

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl
  import vec_irq_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int DATA_W  = 32,
  parameter int PRIO_W  = 4,
  parameter int ADDR_W  = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] irq_lines,
  input  logic               bus_sel,
  input  logic               bus_wr,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  output logic               cpu_irq
);

  localparam int NUM_LVL = 1 << PRIO_W;
  localparam int IDX_W   = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;
  localparam int CNT_W   = $clog2(NUM_LVL + 1);

  logic [NUM_SRC-1:0][DATA_W-1:0] vec_tbl;
  logic [NUM_SRC-1:0][PRIO_W-1:0] prio_tbl;
  logic [NUM_SRC-1:0]             src_en;
  logic [NUM_LVL-1:0]             lvl_mask;
  logic [DATA_W-1:0]              reg_rdata;

  logic              win_valid;
  logic [IDX_W-1:0]  win_idx;
  logic [PRIO_W-1:0] win_prio;

  logic              stk_empty;
  logic [PRIO_W-1:0] stk_top;
  logic [CNT_W-1:0]  stk_depth;

  reg_region_e       rgn;
  logic              ack_rd, retire_wr, qualify, push;
  logic [DATA_W-1:0] win_vec, cur_addr;
  logic              irq_q;

  vec_irq_regs #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W), .PRIO_W(PRIO_W), .ADDR_W(ADDR_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (bus_sel & bus_wr),
    .addr     (bus_addr),
    .wdata    (bus_wdata),
    .rdata    (reg_rdata),
    .vec_tbl  (vec_tbl),
    .prio_tbl (prio_tbl),
    .src_en   (src_en),
    .lvl_mask (lvl_mask)
  );

  vec_irq_arb #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W)) u_arb (
    .irq_lines (irq_lines),
    .src_en    (src_en),
    .lvl_mask  (lvl_mask),
    .prio_tbl  (prio_tbl),
    .win_valid (win_valid),
    .win_idx   (win_idx),
    .win_prio  (win_prio)
  );

  vec_irq_stack #(.PRIO_W(PRIO_W)) u_stack (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (push),
    .push_lvl (win_prio),
    .pop      (retire_wr),
    .empty    (stk_empty),
    .top_lvl  (stk_top),
    .depth    (stk_depth)
  );

  assign rgn       = region_of(32'(bus_addr), NUM_SRC);
  assign ack_rd    = bus_sel & ~bus_wr & (rgn == RG_ACT);
  assign retire_wr = bus_sel &  bus_wr & (rgn == RG_ACT);

  // The winner is already the most urgent source, so comparing it alone suffices.
  assign qualify = win_valid & (stk_empty | (win_prio < stk_top));
  assign push    = ack_rd & qualify;
  assign win_vec = vec_tbl[win_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_addr <= '0;
      irq_q    <= 1'b0;
    end else begin
      irq_q <= qualify;
      if (push) cur_addr <= win_vec;
    end
  end

  always_comb begin
    if (!bus_sel || bus_wr)   bus_rdata = '0;
    else if (rgn == RG_ACT)   bus_rdata = qualify ? win_vec : cur_addr;
    else                      bus_rdata = reg_rdata;
  end

  assign cpu_irq = irq_q;

endmodule

// File: rtl/vec_irq_ctrl_chk.sv
module vec_irq_ctrl_chk #(
  parameter int NUM_SRC = 32,
  parameter int DATA_W  = 32,
  parameter int PRIO_W  = 4
) (
  input logic                             clk,
  input logic                             rst_n,
  input logic [NUM_SRC-1:0]               irq_lines,
  input logic                             cpu_irq,
  input logic                             push,
  input logic                             pop,
  input logic                             ack_rd,
  input logic                             qualify,
  input logic [PRIO_W-1:0]                win_prio,
  input logic                             stk_empty,
  input logic [PRIO_W-1:0]                stk_top,
  input logic [$clog2((1<<PRIO_W)+1)-1:0] stk_depth,
  input logic [DATA_W-1:0]                cur_addr
);

  localparam int DEPTH = 1 << PRIO_W;
  localparam int CNT_W = $clog2(DEPTH + 1);

  assert_no_overflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
    stk_depth <= CNT_W'(DEPTH));

  assert_quiet_lines_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(|irq_lines) |-> !cpu_irq);

  assert_push_level_R6: assert property (@(posedge clk) disable iff (!rst_n)
    push |=> (stk_top == $past(win_prio)) && (stk_depth == $past(stk_depth) + 1'b1));

  assert_nest_deeper_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !stk_empty) |=> stk_top < $past(stk_top));

  assert_retire_pop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !stk_empty) |=> stk_depth == $past(stk_depth) - 1'b1);

  assert_retire_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && stk_empty) |=> stk_empty);

  assert_idle_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_rd && !qualify) |=> $stable(cur_addr) && $stable(stk_depth));

endmodule

bind vec_irq_ctrl vec_irq_ctrl_chk #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W), .PRIO_W(PRIO_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .irq_lines (irq_lines),
  .cpu_irq   (cpu_irq),
  .push      (push),
  .pop       (retire_wr),
  .ack_rd    (ack_rd),
  .qualify   (qualify),
  .win_prio  (win_prio),
  .stk_empty (stk_empty),
  .stk_top   (stk_top),
  .stk_depth (stk_depth),
  .cur_addr  (cur_addr)
);

// File: tb/vec_irq_ctrl_bench.sv
`timescale 1ns/1ps
module vec_irq_ctrl_bench;

  localparam logic [7:0] A_EN   = 8'h40;
  localparam logic [7:0] A_MASK = 8'h41;
  localparam logic [7:0] A_ACT  = 8'h42;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] irq = '0;
  logic        sel = 1'b0, wr = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        cpu_irq;

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  vec_irq_ctrl u_vec_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .irq_lines(irq), .bus_sel(sel), .bus_wr(wr),
    .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata), .cpu_irq(cpu_irq)
  );

  typedef struct packed {
    logic [31:0] lines;
    logic [31:0] en;
    logic [15:0] mask;
    logic [5:0]  exp;   // 32 = no request expected
  } vec_t;

  // Priorities set below: source n sits at level 15 - (n mod 16).
  localparam vec_t TBL [12] = '{
    '{32'h0000_0001, 32'hFFFF_FFFF, 16'hFFFF, 6'd0},
    '{32'h0000_0003, 32'hFFFF_FFFF, 16'hFFFF, 6'd1},
    '{32'h8000_8000, 32'hFFFF_FFFF, 16'hFFFF, 6'd15},
    '{32'h8000_0000, 32'hFFFF_FFFF, 16'hFFFF, 6'd31},
    '{32'h8000_8000, 32'hFFFF_7FFF, 16'hFFFF, 6'd31},
    '{32'h8000_8001, 32'hFFFF_FFFF, 16'hFFFE, 6'd0},
    '{32'hFFFF_FFFF, 32'hFFFF_FFFF, 16'h0000, 6'd32},
    '{32'hFFFF_FFFF, 32'hFFFF_FFFF, 16'h0100, 6'd7},
    '{32'h0000_0000, 32'hFFFF_FFFF, 16'hFFFF, 6'd32},
    '{32'h0001_0000, 32'h0000_FFFF, 16'hFFFF, 6'd32},
    '{32'h0030_0000, 32'hFFFF_FFFF, 16'hFFFF, 6'd21},
    '{32'hFFFF_FFFF, 32'h0000_0000, 16'hFFFF, 6'd32}
  };

  function automatic logic [31:0] vec_of(input int n);
    return 32'hA000_0000 | (32'(n) << 4);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
    @(negedge clk); sel = 1'b0; wr = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); sel = 1'b1; wr = 1'b0; addr = a;
    #1 d = rdata;
    @(negedge clk); sel = 1'b0;
  endtask

  task automatic set_lines(input logic [31:0] v);
    @(negedge clk); irq = v;
  endtask

  task automatic settle();
    @(negedge clk); @(negedge clk);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 irq", 32'(cpu_irq), 0);
    bus_read(A_ACT, d);  chk("R1 act", d, 0);
    bus_read(A_MASK, d); chk("R1 mask", d, 32'h0000_FFFF);
    bus_read(A_EN, d);   chk("R1 en", d, 0);
    bus_read(8'h25, d);  chk("R1 prio", d, 0);
    bus_read(8'h07, d);  chk("R1 vec", d, 0);

    // Program handler addresses and levels
    for (int n = 0; n < 32; n++) begin
      bus_write(8'(n), vec_of(n));
      bus_write(8'(8'h20 + n), 32'hFFFF_FFF0 | 32'(15 - (n % 16)));
    end

    // R2 read-back, upper priority bits, unused words
    bus_read(8'h13, d); chk("R2 vec", d, vec_of(19));
    bus_read(8'h23, d); chk("R2 prio", d, 32'd12);
    bus_write(8'h50, 32'h0000_0000);
    bus_read(8'h50, d); chk("R2 unused", d, 0);
    bus_read(A_MASK, d); chk("R2 unused write", d, 32'h0000_FFFF);

    // Table walk: gating, arbitration and tie-breaking
    for (int t = 0; t < 12; t++) begin
      bus_write(A_EN, TBL[t].en);
      bus_write(A_MASK, 32'(TBL[t].mask));
      set_lines(TBL[t].lines);
      settle();
      chk($sformatf("R3 entry %0d irq", t), 32'(cpu_irq), 32'(TBL[t].exp != 6'd32));
      if (TBL[t].exp != 6'd32) begin
        bus_read(A_ACT, d);
        chk($sformatf("R4 entry %0d vector", t), d, vec_of(int'(TBL[t].exp)));
        set_lines(0);
        bus_write(A_ACT, 32'h0);
      end
      set_lines(0);
    end

    bus_write(A_EN, 32'hFFFF_FFFF);
    bus_write(A_MASK, 32'h0000_FFFF);
    settle();

    // R5 registered request
    @(negedge clk); irq = 32'h1;
    #1 chk("R5 same cycle", 32'(cpu_irq), 0);
    @(negedge clk);
    chk("R5 next edge", 32'(cpu_irq), 1);
    set_lines(0);
    settle();

    // R6 / R7 / R10: nest through all 16 levels
    for (int s = 0; s < 16; s++) begin
      set_lines(irq | (32'h1 << s));
      settle();
      chk($sformatf("R7 level %0d raises", 15 - s), 32'(cpu_irq), 1);
      bus_read(A_ACT, d);
      chk($sformatf("R10 ack depth %0d", s + 1), d, vec_of(s));
      settle();
      chk($sformatf("R7 same level %0d quiet", 15 - s), 32'(cpu_irq), 0);
    end
    bus_read(A_ACT, d);
    chk("R6 latched after nest", d, vec_of(15));
    set_lines(irq | 32'h8000_0000);
    settle();
    chk("R7 tie with serviced level 0", 32'(cpu_irq), 0);

    // R8 retire re-exposes pending level 0; tie goes to source 15
    bus_write(A_ACT, 32'h1234_5678);
    settle();
    chk("R8 retire exposes", 32'(cpu_irq), 1);
    bus_read(A_ACT, d);
    chk("R4 tie after retire", d, vec_of(15));
    set_lines(0);
    for (int k = 0; k < 16; k++) bus_write(A_ACT, 32'hFFFF_FFFF);
    bus_write(A_ACT, 32'h0);   // extra retire on an empty stack
    set_lines(32'h1);          // level 15 can only win if the stack is empty
    settle();
    chk("R8 empty after retires", 32'(cpu_irq), 1);
    bus_read(A_ACT, d);
    chk("R6 least urgent ack", d, vec_of(0));
    set_lines(0);
    bus_write(A_ACT, 32'h0);
    settle();
    chk("R8 quiet after last retire", 32'(cpu_irq), 0);

    // R9 idle read returns last address and leaves the stack alone
    set_lines(32'h1 << 10);    // level 5
    settle();
    bus_read(A_ACT, d); chk("R6 ack level 5", d, vec_of(10));
    set_lines(0);
    settle();
    bus_read(A_ACT, d); chk("R9 idle read", d, vec_of(10));
    set_lines(32'h1 << 9);     // level 6
    settle();
    chk("R7 level 6 held off", 32'(cpu_irq), 0);
    bus_write(A_ACT, 32'h0);
    settle();
    chk("R9 one retire suffices", 32'(cpu_irq), 1);
    bus_read(A_ACT, d); chk("R9 next vector", d, vec_of(9));
    set_lines(0);
    bus_write(A_ACT, 32'h0);
    settle();
    chk("R8 final quiet", 32'(cpu_irq), 0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule